// File: doc/BRIEF.md
# Load-Store Queue Allocation Tracker

This block keeps the books for the load and store queues of an out-of-order core. It does not hold addresses or data. A new memory instruction asks for an entry and gets back an index from a free-index pool: one pool for loads and one for stores. The block files the instruction's sequence number at the young end of the matching age-ordered queue. The index goes back to its pool when the entry leaves, whether it retires, launches to memory, or is thrown away on a squash.

Entries leave or change state in three ways, each decided by comparing sequence numbers. A commit carries the youngest committed sequence number. It retires every load at or below that number, and it marks every store at or below it as allowed to write back. A squash carries a boundary and removes every younger entry from both queues. A store that may write back leaves the queue when its send is issued. It then counts as in flight until memory confirms it. The block also reports a combined free-entry count that dispatch logic can use. The count keeps one slot in reserve. The block records one blocked load, and a squash that reaches below it releases it.

Top module: `lsq_alloc_tracker`

## Requirements
- R1: After synchronous reset, both queues and the in-flight count are zero, no load is blocked, every index of both pools is free, and `free_entries` reads min(LQ_ENT, SQ_ENT) - 1.
- R2: An accepted insert raises `ins_ok` in the same cycle and returns on `ins_idx` the lowest-numbered free index of the requested pool. From the next cycle the entry is counted at the young end of its queue.
- R3: The load pool holds 2*LQ_ENT indices. When no load index is free, a load insert is refused: `ins_full` = 1, `ins_ok` = 0, and `ld_count` is unchanged.
- R4: The store pool holds SQ_ENT indices. When no store index is free, a store insert is refused with `ins_full` = 1, and `st_count` is unchanged.
- R5: `free_entries` = max(0, min(max(0, LQ_ENT - ld_count), max(0, SQ_ENT - st_count - st_inflight)) - 1).
- R6: A commit retires every resident load whose sequence number is less than or equal to `commit_seq`. Their indices become allocatable from the next cycle.
- R7: A commit marks every resident store whose sequence number is at or below `commit_seq` as eligible for writeback. `st_wb_pending` counts the eligible resident stores.
- R8: `wb_send` is accepted (`wb_ok` = 1, `wb_idx` = that store's index) only when the oldest store is eligible, no squash is present, and fewer than SQ_ENT stores are in flight. An accepted send removes the store, frees its index and raises `st_inflight` by one. `wb_done` lowers `st_inflight` by one.
- R9: A squash removes from both queues every entry whose sequence number is greater than `squash_seq`, and frees their indices. An insert in a squash cycle is neither accepted nor flagged full.
- R10: Squashing a store that is eligible for writeback lowers `st_wb_pending` by one for that store.
- R11: `blk_valid` records a blocked load and its sequence number, and raises `ld_blocked`. A squash with `squash_seq` below the recorded number clears it. A squash at or above that number leaves it set.
- R12: A commit and a load insert in the same cycle are both honoured. The insert takes an index that was free before the commit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ins_valid | input | 1 | Insert request |
| ins_is_store | input | 1 | 1 = store, 0 = load |
| ins_seq | input | SEQ_W | Sequence number of the inserted instruction |
| commit_valid | input | 1 | Commit request |
| commit_seq | input | SEQ_W | Youngest committed sequence number |
| squash_valid | input | 1 | Squash request |
| squash_seq | input | SEQ_W | Squash boundary; younger entries are removed |
| blk_valid | input | 1 | Record a blocked load |
| blk_seq | input | SEQ_W | Sequence number of the blocked load |
| wb_send | input | 1 | Launch the oldest eligible store to memory |
| wb_done | input | 1 | One in-flight store has completed |
| ins_ok | output | 1 | Insert accepted this cycle |
| ins_full | output | 1 | Insert refused, pool empty |
| ins_idx | output | clog2(max(2*LQ_ENT, SQ_ENT)) | Allocated index |
| wb_ok | output | 1 | Send accepted this cycle |
| wb_idx | output | clog2(SQ_ENT) | Index of the oldest store |
| free_entries | output | clog2(LQ_ENT+2) | Combined free count with one slot reserved |
| ld_count | output | clog2(2*LQ_ENT+1) | Resident loads |
| st_count | output | clog2(SQ_ENT+1) | Resident stores |
| st_wb_pending | output | clog2(SQ_ENT+1) | Resident stores eligible for writeback |
| st_inflight | output | clog2(SQ_ENT+1) | Stores sent but not yet completed |
| ld_blocked | output | 1 | A blocked load is recorded |

## Verification
The bench fills the load pool past LQ_ENT until it runs dry. A tracker that sized that pool at LQ_ENT would refuse too early. One with a missing clamp would report a wrapped, huge free count. The bench also issues a commit together with an insert, and checks that the insert index comes from before the commit. A tracker that reused the just-retired index, or dropped one of the two operations, would show a wrong index or count. Squash boundaries are placed both below and at or above the blocked load, and one squash removes an eligible store. These cases catch an inverted comparison or a stale writeback-pending count. A send aimed at an ineligible oldest store must be refused; a tracker that ignores the eligibility mark would instead launch that store.

// File: rtl/lsq_alloc_tracker.sv
module lsq_alloc_tracker #(
  parameter int LQ_ENT = 4,
  parameter int SQ_ENT = 4,
  parameter int SEQ_W  = 16
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     ins_valid,
  input  logic                     ins_is_store,
  input  logic [SEQ_W-1:0]         ins_seq,
  input  logic                     commit_valid,
  input  logic [SEQ_W-1:0]         commit_seq,
  input  logic                     squash_valid,
  input  logic [SEQ_W-1:0]         squash_seq,
  input  logic                     blk_valid,
  input  logic [SEQ_W-1:0]         blk_seq,
  input  logic                     wb_send,
  input  logic                     wb_done,
  output logic                     ins_ok,
  output logic                     ins_full,
  output logic [$clog2((2*LQ_ENT > SQ_ENT) ? 2*LQ_ENT : SQ_ENT)-1:0] ins_idx,
  output logic                     wb_ok,
  output logic [$clog2(SQ_ENT)-1:0] wb_idx,
  output logic [$clog2(LQ_ENT+2)-1:0] free_entries,
  output logic [$clog2(2*LQ_ENT+1)-1:0] ld_count,
  output logic [$clog2(SQ_ENT+1)-1:0] st_count,
  output logic [$clog2(SQ_ENT+1)-1:0] st_wb_pending,
  output logic [$clog2(SQ_ENT+1)-1:0] st_inflight,
  output logic                     ld_blocked
);
  localparam int LQ_SLOTS = 2 * LQ_ENT;
  localparam int LIW  = $clog2(LQ_SLOTS);
  localparam int SIW  = $clog2(SQ_ENT);
  localparam int IDXW = $clog2((LQ_SLOTS > SQ_ENT) ? LQ_SLOTS : SQ_ENT);
  localparam int LCW  = $clog2(LQ_SLOTS + 1);
  localparam int SCW  = $clog2(SQ_ENT + 1);
  localparam int FW   = $clog2(LQ_ENT + 2);

  logic [SEQ_W-1:0]    ld_seq [LQ_SLOTS];
  logic [LIW-1:0]      ld_idx [LQ_SLOTS];
  logic [LCW-1:0]      ld_cnt;
  logic [LQ_SLOTS-1:0] lpool;
  logic [SEQ_W-1:0]    st_seq [SQ_ENT];
  logic [SIW-1:0]      st_idx [SQ_ENT];
  logic [SQ_ENT-1:0]   st_wb;
  logic [SCW-1:0]      st_cnt, inflight;
  logic [SQ_ENT-1:0]   spool;
  logic                blocked;
  logic [SEQ_W-1:0]    blk_seq_q;

  logic [SEQ_W-1:0]    n_lseq [LQ_SLOTS];
  logic [LIW-1:0]      n_lidx [LQ_SLOTS];
  logic [LCW-1:0]      n_lcnt;
  logic [LQ_SLOTS-1:0] n_lpool;
  logic [SEQ_W-1:0]    n_sseq [SQ_ENT];
  logic [SIW-1:0]      n_sidx [SQ_ENT];
  logic [SQ_ENT-1:0]   n_swb, n_spool;
  logic [SCW-1:0]      n_scnt;

  logic [LIW-1:0] l_head;
  logic [SIW-1:0] s_head;
  logic           l_any, s_any, ld_ins, st_ins, st_send;

  always_comb begin
    l_any = 1'b0; l_head = '0;
    for (int i = LQ_SLOTS-1; i >= 0; i--)
      if (lpool[i]) begin l_any = 1'b1; l_head = LIW'(i); end
    s_any = 1'b0; s_head = '0;
    for (int i = SQ_ENT-1; i >= 0; i--)
      if (spool[i]) begin s_any = 1'b1; s_head = SIW'(i); end
  end

  assign ld_ins   = ins_valid && !ins_is_store && !squash_valid && l_any;
  assign st_ins   = ins_valid &&  ins_is_store && !squash_valid && s_any;
  assign ins_ok   = ld_ins || st_ins;
  assign ins_full = ins_valid && !squash_valid && (ins_is_store ? !s_any : !l_any);
  assign ins_idx  = ins_is_store ? IDXW'(s_head) : IDXW'(l_head);
  assign st_send  = wb_send && !squash_valid && (st_cnt != '0) && st_wb[0]
                    && (int'(inflight) < SQ_ENT);
  assign wb_ok    = st_send;
  assign wb_idx   = st_idx[0];

  always_comb begin
    int lk;
    n_lseq = ld_seq; n_lidx = ld_idx; n_lpool = lpool; n_lcnt = ld_cnt; lk = 0;
    if (squash_valid) begin
      for (int i = 0; i < LQ_SLOTS; i++)
        if (i < int'(ld_cnt)) begin
          if (ld_seq[i] <= squash_seq) lk++;
          else n_lpool[ld_idx[i]] = 1'b1;
        end
      n_lcnt = LCW'(lk);
    end else begin
      if (commit_valid)
        for (int i = 0; i < LQ_SLOTS; i++)
          if (i < int'(ld_cnt) && ld_seq[i] <= commit_seq) begin
            lk++; n_lpool[ld_idx[i]] = 1'b1;
          end
      for (int i = 0; i < LQ_SLOTS; i++)
        if (i >= lk) begin n_lseq[i-lk] = ld_seq[i]; n_lidx[i-lk] = ld_idx[i]; end
      n_lcnt = ld_cnt - LCW'(lk);
      if (ld_ins) begin
        n_lseq[n_lcnt[LIW-1:0]] = ins_seq;
        n_lidx[n_lcnt[LIW-1:0]] = l_head;
        n_lpool[l_head] = 1'b0;
        n_lcnt = n_lcnt + 1'b1;
      end
    end
  end

  always_comb begin
    int sk;
    n_sseq = st_seq; n_sidx = st_idx; n_swb = st_wb; n_spool = spool; n_scnt = st_cnt; sk = 0;
    if (squash_valid) begin
      for (int i = 0; i < SQ_ENT; i++)
        if (i < int'(st_cnt)) begin
          if (st_seq[i] <= squash_seq) sk++;
          else n_spool[st_idx[i]] = 1'b1;
        end
      n_scnt = SCW'(sk);
    end else begin
      if (commit_valid)
        for (int i = 0; i < SQ_ENT; i++)
          if (i < int'(st_cnt) && st_seq[i] <= commit_seq) n_swb[i] = 1'b1;
      if (st_send) begin
        sk = 1;
        n_spool[st_idx[0]] = 1'b1;
        for (int i = 1; i < SQ_ENT; i++) begin
          n_sseq[i-1] = st_seq[i]; n_sidx[i-1] = st_idx[i]; n_swb[i-1] = n_swb[i];
        end
      end
      n_scnt = st_cnt - SCW'(sk);
      if (st_ins) begin
        n_sseq[n_scnt[SIW-1:0]] = ins_seq;
        n_sidx[n_scnt[SIW-1:0]] = s_head;
        n_swb[n_scnt[SIW-1:0]]  = 1'b0;
        n_spool[s_head] = 1'b0;
        n_scnt = n_scnt + 1'b1;
      end
    end
    for (int i = 0; i < SQ_ENT; i++)
      if (i >= int'(n_scnt)) n_swb[i] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < LQ_SLOTS; i++) begin ld_seq[i] <= '0; ld_idx[i] <= '0; end
      for (int i = 0; i < SQ_ENT; i++) begin st_seq[i] <= '0; st_idx[i] <= '0; end
      ld_cnt <= '0; lpool <= '1; st_cnt <= '0; st_wb <= '0; spool <= '1;
      inflight <= '0; blocked <= 1'b0; blk_seq_q <= '0;
    end else begin
      ld_seq <= n_lseq; ld_idx <= n_lidx; ld_cnt <= n_lcnt; lpool <= n_lpool;
      st_seq <= n_sseq; st_idx <= n_sidx; st_wb <= n_swb; st_cnt <= n_scnt; spool <= n_spool;
      inflight <= inflight + SCW'(st_send) - SCW'(wb_done && inflight != '0);
      if (squash_valid) begin
        if (blocked && squash_seq < blk_seq_q) begin blocked <= 1'b0; blk_seq_q <= '0; end
      end else if (blk_valid) begin
        blocked <= 1'b1; blk_seq_q <= blk_seq;
      end
    end
  end

  always_comb begin
    int lf, sf, m, c;
    lf = LQ_ENT - int'(ld_cnt);                  if (lf < 0) lf = 0;
    sf = SQ_ENT - int'(st_cnt) - int'(inflight); if (sf < 0) sf = 0;
    m = ((lf < sf) ? lf : sf) - 1;               if (m < 0) m = 0;
    free_entries = FW'(m);
    c = 0;
    for (int i = 0; i < SQ_ENT; i++) c += int'(st_wb[i]);
    st_wb_pending = SCW'(c);
  end

  assign ld_count    = ld_cnt;
  assign st_count    = st_cnt;
  assign st_inflight = inflight;
  assign ld_blocked  = blocked;

  AST_INS_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(ins_ok && ins_full)); // R2
  AST_LPOOL_CONSERVE: assert property (@(posedge clk) disable iff (rst)
    $countones(lpool) + int'(ld_cnt) == LQ_SLOTS); // R3
  AST_SPOOL_CONSERVE: assert property (@(posedge clk) disable iff (rst)
    $countones(spool) + int'(st_cnt) == SQ_ENT); // R4
  AST_FULL_HOLD: assert property (@(posedge clk) disable iff (rst)
    ins_full && !ins_is_store && !commit_valid |=> ld_count == $past(ld_count)); // R3
  AST_WB_BOUND: assert property (@(posedge clk) disable iff (rst)
    st_wb_pending <= st_count); // R7
  AST_INFLIGHT_BOUND: assert property (@(posedge clk) disable iff (rst)
    int'(st_inflight) <= SQ_ENT); // R8
  AST_SQUASH_UNBLOCK: assert property (@(posedge clk) disable iff (rst)
    squash_valid && ld_blocked && squash_seq < blk_seq_q |=> !ld_blocked); // R11
endmodule

// File: tb/lsq_alloc_tracker_tb.sv
module lsq_alloc_tracker_tb;
  localparam int CLK_PERIOD = 10;
  localparam int LQ_ENT = 4, SQ_ENT = 4, SEQ_W = 16;

  logic clk = 1'b0, rst = 1'b1;
  logic ins_valid = 0, ins_is_store = 0, commit_valid = 0, squash_valid = 0;
  logic blk_valid = 0, wb_send = 0, wb_done = 0;
  logic [SEQ_W-1:0] ins_seq = '0, commit_seq = '0, squash_seq = '0, blk_seq = '0;
  logic ins_ok, ins_full, wb_ok, ld_blocked;
  logic [2:0] ins_idx;
  logic [1:0] wb_idx;
  logic [2:0] free_entries;
  logic [3:0] ld_count;
  logic [2:0] st_count, st_wb_pending, st_inflight;

  lsq_alloc_tracker #(.LQ_ENT(LQ_ENT), .SQ_ENT(SQ_ENT), .SEQ_W(SEQ_W)) u_dut (
    .clk, .rst, .ins_valid, .ins_is_store, .ins_seq, .commit_valid, .commit_seq,
    .squash_valid, .squash_seq, .blk_valid, .blk_seq, .wb_send, .wb_done,
    .ins_ok, .ins_full, .ins_idx, .wb_ok, .wb_idx, .free_entries, .ld_count,
    .st_count, .st_wb_pending, .st_inflight, .ld_blocked);

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef enum {K_OK, K_FULL, K_IDX, K_FREE, K_LDC, K_STC, K_WBP, K_INF, K_BLK, K_WBOK, K_WBIDX} kind_e;
  typedef struct { kind_e k; int exp; string req; } item_t;
  item_t sb[$];
  event chk_ev;
  int n_cmp = 0, n_bad = 0;
  bit finished = 0;

  function automatic int probe(kind_e k);
    case (k)
      K_OK:    return int'(ins_ok);
      K_FULL:  return int'(ins_full);
      K_IDX:   return int'(ins_idx);
      K_FREE:  return int'(free_entries);
      K_LDC:   return int'(ld_count);
      K_STC:   return int'(st_count);
      K_WBP:   return int'(st_wb_pending);
      K_INF:   return int'(st_inflight);
      K_BLK:   return int'(ld_blocked);
      K_WBOK:  return int'(wb_ok);
      default: return int'(wb_idx);
    endcase
  endfunction

  initial forever begin
    @(chk_ev);
    while (sb.size() > 0) begin
      item_t it;
      int act;
      it = sb.pop_front();
      act = probe(it.k);
      n_cmp++;
      if (act !== it.exp) begin
        n_bad++;
        $display("FAIL %s: %s actual=%0d expected=%0d", it.req, it.k.name(), act, it.exp);
      end
    end
  end

  task automatic want(kind_e k, int e, string r);
    item_t it;
    it.k = k; it.exp = e; it.req = r;
    sb.push_back(it);
  endtask
  task automatic flush(); -> chk_ev; #1; endtask
  task automatic tick(); @(posedge clk); #2; endtask
  task automatic idle();
    ins_valid = 0; commit_valid = 0; squash_valid = 0; blk_valid = 0; wb_send = 0; wb_done = 0;
  endtask
  task automatic do_ins(bit st, int seq, int ok, int idx, string r);
    ins_valid = 1; ins_is_store = st; ins_seq = SEQ_W'(seq); #1;
    want(K_OK, ok, r); want(K_FULL, ok ? 0 : 1, r);
    if (ok) want(K_IDX, idx, r);
    flush(); tick(); idle();
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      n_bad++; n_cmp++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    rst = 0; tick();
    want(K_LDC, 0, "R1"); want(K_STC, 0, "R1"); want(K_FREE, 3, "R1");
    want(K_WBP, 0, "R1"); want(K_INF, 0, "R1"); want(K_BLK, 0, "R1"); flush();

    do_ins(0, 10, 1, 0, "R2");
    want(K_LDC, 1, "R2"); want(K_FREE, 2, "R5"); flush();
    do_ins(1, 11, 1, 0, "R2");
    want(K_STC, 1, "R2"); want(K_FREE, 2, "R5"); flush();
    for (int s = 12; s <= 18; s++) do_ins(0, s, 1, s - 11, "R3");
    want(K_LDC, 8, "R3"); want(K_FREE, 0, "R5"); flush();
    do_ins(0, 19, 0, 0, "R3");
    want(K_LDC, 8, "R3"); flush();

    commit_valid = 1; commit_seq = 13; tick(); idle();
    want(K_LDC, 5, "R6"); want(K_WBP, 1, "R7"); flush();
    do_ins(0, 21, 1, 0, "R6");
    want(K_LDC, 6, "R6"); flush();
    commit_valid = 1; commit_seq = 15;
    do_ins(0, 22, 1, 1, "R12");
    want(K_LDC, 5, "R12"); flush();

    do_ins(1, 23, 1, 1, "R2");
    do_ins(1, 24, 1, 2, "R2");
    do_ins(1, 25, 1, 3, "R2");
    want(K_STC, 4, "R4"); flush();
    do_ins(1, 26, 0, 0, "R4");
    want(K_STC, 4, "R4"); flush();

    wb_send = 1; #1;
    want(K_WBOK, 1, "R8"); want(K_WBIDX, 0, "R8"); flush();
    tick(); idle();
    want(K_STC, 3, "R8"); want(K_INF, 1, "R8"); want(K_WBP, 0, "R8"); flush();
    wb_send = 1; #1;
    want(K_WBOK, 0, "R8"); flush();
    tick(); idle();
    want(K_STC, 3, "R8"); flush();

    commit_valid = 1; commit_seq = 23; tick(); idle();
    want(K_LDC, 0, "R6"); want(K_WBP, 1, "R7"); want(K_FREE, 0, "R5"); flush();
    wb_done = 1; tick(); idle();
    want(K_INF, 0, "R8"); want(K_FREE, 0, "R5"); flush();

    do_ins(0, 26, 1, 0, "R2");
    do_ins(0, 27, 1, 1, "R2");
    blk_valid = 1; blk_seq = 23; tick(); idle();
    want(K_BLK, 1, "R11"); flush();
    squash_valid = 1; squash_seq = 24; tick(); idle();
    want(K_LDC, 0, "R9"); want(K_STC, 2, "R9"); want(K_WBP, 1, "R9");
    want(K_BLK, 1, "R11"); flush();
    squash_valid = 1; squash_seq = 22;
    ins_valid = 1; ins_is_store = 0; ins_seq = 40; #1;
    want(K_OK, 0, "R9"); want(K_FULL, 0, "R9"); flush();
    tick(); idle();
    want(K_STC, 0, "R9"); want(K_WBP, 0, "R10"); want(K_BLK, 0, "R11");
    want(K_LDC, 0, "R9"); flush();

    do_ins(1, 50, 1, 0, "R9");
    do_ins(0, 51, 1, 0, "R9");
    want(K_STC, 1, "R2"); want(K_LDC, 1, "R2"); want(K_FREE, 2, "R5"); flush();

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule